// File: doc/BRIEF.md
# Shared Bus Register Transfer Datapath

This block is a small register-transfer datapath. Four general registers, an address register and a data register all sit on one shared bus, and a synchronous word memory sits behind them. In each clock cycle a two-bit source code picks the value that drives the bus: one of the four registers, or a literal taken from an input port. A two-bit destination code goes through a one-hot decoder. When the load enable and the transfer condition are both 1, exactly one register captures the bus on the rising clock edge. The address register and the data register have their own load strobes from the bus, and the transfer condition gates them as well.

Memory microoperations go through the address register and the data register. A write stores the data register at the word that the low address bits select. A read loads the data register from that word on the clock edge. Both need the chip select. Because the bus can be read and loaded in the same cycle, one cycle performs a full register-to-register move. The registers are observed by selecting them onto the bus.

Top module: `bus_xfer_datapath`

## Requirements
- R1: With `lit_en`=0, `bus_data` equals register A, B, C or D for `src_sel` 00, 01, 10 and 11 respectively. With `lit_en`=1, `bus_data` equals `lit_data`.
- R2: When `ld_en`=1 and `cond`=1, the register named by `dst_sel` (00=A, 01=B, 10=C, 11=D) takes `bus_data`, and the other three registers keep their values.
- R3: Loads take effect only at the rising clock edge. Before that edge, register, `ar_q` and `dr_q` values are unchanged even while the load strobes are high.
- R4: When `cond`=0, no general register, `ar_q` or `dr_q` is loaded from the bus, whatever `ld_en`, `ar_ld` and `dr_ld` are.
- R5: A single cycle with source i and destination j copies register i into register j. When i equals j, the register keeps its value.
- R6: With `cond`=1, `ar_ld`=1 loads `ar_q` from the bus, and `dr_ld`=1 loads `dr_q` from the bus.
- R7: `cs`=1 with `wr_en`=1 stores `dr_q` into the memory word addressed by `ar_q`.
- R8: `cs`=1 with `rd_en`=1 and `wr_en`=0 loads `dr_q` from the memory word addressed by `ar_q` at the clock edge. This takes priority over `dr_ld`.
- R9: With `cs`=0, neither a read nor a write takes place.
- R10: When `rd_en` and `wr_en` are both 1 under `cs`, the write is performed and `dr_q` is not loaded from memory.
- R11: A synchronous active-high `rst` clears A to D, `ar_q` and `dr_q` to zero and overrides any load.
- R12: Only the low `ADDR_W` bits of `ar_q` address the memory, so addresses that differ only in higher bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Bus source register code |
| lit_en | input | 1 | Drive `lit_data` onto the bus instead of a register |
| lit_data | input | DATA_W | Literal value for constant loads |
| dst_sel | input | 2 | Destination register code |
| ld_en | input | 1 | General register load enable |
| cond | input | 1 | Transfer condition gating all bus loads |
| ar_ld | input | 1 | Load address register from bus |
| dr_ld | input | 1 | Load data register from bus |
| cs | input | 1 | Memory chip select |
| rd_en | input | 1 | Memory read request |
| wr_en | input | 1 | Memory write request |
| bus_data | output | DATA_W | Current shared bus value |
| ar_q | output | DATA_W | Address register |
| dr_q | output | DATA_W | Data register |

## Verification
The bench builds the block with its default 16-bit words and an 8-bit memory address. With these values the full 256-word memory is reachable, and the upper byte of the address register can be set to show address aliasing. A behavioural model predicts every register, the address and data registers and the memory contents on each clock. After each edge the bench reads all four registers back across the bus. The memory cases write a word and then check it by reading it back, which covers writes without chip select and the write-over-read case.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
   localparam int NREG  = 4;
   localparam int SEL_W = $clog2(NREG);

   typedef enum logic [SEL_W-1:0] {
      RID_A = 2'd0,
      RID_B = 2'd1,
      RID_C = 2'd2,
      RID_D = 2'd3
   } reg_id_e;
endpackage

// File: rtl/bus_src_mux.sv
module bus_src_mux #(
   parameter int DATA_W = 16,
   parameter int NREG   = 4,
   localparam int SEL_W = $clog2(NREG)
) (
   input  logic [NREG-1:0][DATA_W-1:0] regs,
   input  logic [SEL_W-1:0]            sel,
   output logic [DATA_W-1:0]           dout
);
   always_comb begin
      dout = regs[sel];
   end
endmodule

// File: rtl/dst_decoder.sv
module dst_decoder #(
   parameter int NREG   = 4,
   localparam int SEL_W = $clog2(NREG)
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             en,
   output logic [NREG-1:0]  onehot
);
   for (genvar g = 0; g < NREG; g++) begin : g_dec
      assign onehot[g] = en && (sel == SEL_W'(g));
   end
endmodule

// File: rtl/word_mem.sv
module word_mem #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[addr] <= wdata;
   end

   assign rdata = store[addr];
endmodule

// File: rtl/bus_xfer_datapath.sv
module bus_xfer_datapath
   import xfer_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  src_sel,
   input  logic              lit_en,
   input  logic [DATA_W-1:0] lit_data,
   input  logic [SEL_W-1:0]  dst_sel,
   input  logic              ld_en,
   input  logic              cond,
   input  logic              ar_ld,
   input  logic              dr_ld,
   input  logic              cs,
   input  logic              rd_en,
   input  logic              wr_en,
   output logic [DATA_W-1:0] bus_data,
   output logic [DATA_W-1:0] ar_q,
   output logic [DATA_W-1:0] dr_q
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must lie in 1..12");
   end
   if (DATA_W < ADDR_W) begin : g_bad_width
      $error("DATA_W must hold a full memory address");
   end

   logic [NREG-1:0][DATA_W-1:0] reg_q;
   logic [NREG-1:0]             ld_vec;
   logic [DATA_W-1:0]           mux_out;
   logic [DATA_W-1:0]           mem_rdata;
   logic                        mem_wr;
   logic                        mem_rd;

   bus_src_mux #(.DATA_W(DATA_W), .NREG(NREG)) u_mux (
      .regs (reg_q),
      .sel  (src_sel),
      .dout (mux_out)
   );

   assign bus_data = lit_en ? lit_data : mux_out;

   dst_decoder #(.NREG(NREG)) u_dec (
      .sel    (dst_sel),
      .en     (ld_en & cond),
      .onehot (ld_vec)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)            reg_q[g] <= '0;
         else if (ld_vec[g]) reg_q[g] <= bus_data;
      end
   end

   assign mem_wr = cs & wr_en;
   assign mem_rd = cs & rd_en & ~wr_en;

   word_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk   (clk),
      .we    (mem_wr),
      .addr  (ar_q[ADDR_W-1:0]),
      .wdata (dr_q),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst)                ar_q <= '0;
      else if (ar_ld && cond) ar_q <= bus_data;
   end

   always_ff @(posedge clk) begin
      if (rst)                dr_q <= '0;
      else if (mem_rd)        dr_q <= mem_rdata;
      else if (dr_ld && cond) dr_q <= bus_data;
   end
endmodule

// File: rtl/xfer_checker.sv
module xfer_checker
   import xfer_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic                        clk,
   input logic                        rst,
   input logic [SEL_W-1:0]            src_sel,
   input logic                        lit_en,
   input logic [SEL_W-1:0]            dst_sel,
   input logic                        ld_en,
   input logic                        cond,
   input logic                        ar_ld,
   input logic                        dr_ld,
   input logic                        cs,
   input logic                        rd_en,
   input logic                        wr_en,
   input logic [DATA_W-1:0]           bus_data,
   input logic [DATA_W-1:0]           ar_q,
   input logic [DATA_W-1:0]           dr_q,
   input logic [NREG-1:0][DATA_W-1:0] reg_q,
   input logic [NREG-1:0]             ld_vec,
   input logic [DATA_W-1:0]           mem_rdata
);
   AST_BUS_SOURCE: assert property (@(posedge clk) disable iff (rst)
      !lit_en |-> bus_data == reg_q[src_sel]);                                   // R1
   AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ld_vec));                                                         // R2
   AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      ld_en && cond |=> reg_q[$past(dst_sel)] == $past(bus_data));               // R3
   AST_NO_COND_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(ld_en && cond) |=> $stable(reg_q));                                      // R4
   AST_AR_LOAD: assert property (@(posedge clk) disable iff (rst)
      ar_ld && cond |=> ar_q == $past(bus_data));                                // R6
   AST_MEM_READ: assert property (@(posedge clk) disable iff (rst)
      cs && rd_en && !wr_en |=> dr_q == $past(mem_rdata));                       // R8
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
      cs && rd_en && wr_en && !(dr_ld && cond) |=> $stable(dr_q));               // R10
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> ar_q == '0 && dr_q == '0 && reg_q == '0);                          // R11
endmodule

bind bus_xfer_datapath xfer_checker #(.DATA_W(DATA_W)) i_xfer_checker (
   .clk       (clk),
   .rst       (rst),
   .src_sel   (src_sel),
   .lit_en    (lit_en),
   .dst_sel   (dst_sel),
   .ld_en     (ld_en),
   .cond      (cond),
   .ar_ld     (ar_ld),
   .dr_ld     (dr_ld),
   .cs        (cs),
   .rd_en     (rd_en),
   .wr_en     (wr_en),
   .bus_data  (bus_data),
   .ar_q      (ar_q),
   .dr_q      (dr_q),
   .reg_q     (reg_q),
   .ld_vec    (ld_vec),
   .mem_rdata (mem_rdata)
);

// File: tb/test_bus_xfer_datapath.sv
module test_bus_xfer_datapath;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    src_sel = '0;
   logic          lit_en = 1'b0;
   logic [DW-1:0] lit_data = '0;
   logic [1:0]    dst_sel = '0;
   logic          ld_en = 1'b0;
   logic          cond = 1'b0;
   logic          ar_ld = 1'b0;
   logic          dr_ld = 1'b0;
   logic          cs = 1'b0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] bus_data;
   logic [DW-1:0] ar_q;
   logic [DW-1:0] dr_q;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [DW-1:0] m_reg [4];
   logic [DW-1:0] m_ar;
   logic [DW-1:0] m_dr;
   logic [DW-1:0] m_mem [1 << AW];

   bus_xfer_datapath #(.DATA_W(DW), .ADDR_W(AW)) i_bus_xfer_datapath (
      .clk(clk), .rst(rst), .src_sel(src_sel), .lit_en(lit_en), .lit_data(lit_data),
      .dst_sel(dst_sel), .ld_en(ld_en), .cond(cond), .ar_ld(ar_ld), .dr_ld(dr_ld),
      .cs(cs), .rd_en(rd_en), .wr_en(wr_en), .bus_data(bus_data), .ar_q(ar_q), .dr_q(dr_q)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string tag, input string what, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      src_sel = '0; lit_en = 1'b0; lit_data = '0; dst_sel = '0; ld_en = 1'b0;
      cond = 1'b0; ar_ld = 1'b0; dr_ld = 1'b0; cs = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
   endtask

   // One clock with the inputs the caller set; model updated, all state compared after.
   task automatic cycle(input string tag);
      logic [DW-1:0] eb, n_ar, n_dr;
      logic [DW-1:0] n_reg [4];
      #1;
      eb = lit_en ? lit_data : m_reg[src_sel];
      check(tag, "bus before edge", bus_data, eb);
      check("R3", "ar before edge", ar_q, m_ar);
      check("R3", "dr before edge", dr_q, m_dr);
      for (int k = 0; k < 4; k++) n_reg[k] = m_reg[k];
      n_ar = m_ar;
      n_dr = m_dr;
      if (ld_en && cond) n_reg[dst_sel] = eb;
      if (ar_ld && cond) n_ar = eb;
      if (cs && rd_en && !wr_en) n_dr = m_mem[m_ar[AW-1:0]];
      else if (dr_ld && cond) n_dr = eb;
      if (rst) begin
         for (int k = 0; k < 4; k++) n_reg[k] = '0;
         n_ar = '0;
         n_dr = '0;
      end
      if (!rst && cs && wr_en) m_mem[m_ar[AW-1:0]] = m_dr;
      @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < 4; k++) m_reg[k] = n_reg[k];
      m_ar = n_ar;
      m_dr = n_dr;
      rst = 1'b0;
      idle();
      check(tag, "ar", ar_q, m_ar);
      check(tag, "dr", dr_q, m_dr);
      for (int k = 0; k < 4; k++) begin
         src_sel = 2'(k);
         #0.5;
         check(tag, $sformatf("reg %0d via bus", k), bus_data, m_reg[k]);
      end
      src_sel = '0;
   endtask

   task automatic put_reg(input int k, input logic [DW-1:0] v, input string tag);
      lit_en = 1'b1; lit_data = v; dst_sel = 2'(k); ld_en = 1'b1; cond = 1'b1;
      cycle(tag);
   endtask

   task automatic put_ar(input logic [DW-1:0] v);
      lit_en = 1'b1; lit_data = v; ar_ld = 1'b1; cond = 1'b1;
      cycle("R6");
   endtask

   task automatic put_dr(input logic [DW-1:0] v);
      lit_en = 1'b1; lit_data = v; dr_ld = 1'b1; cond = 1'b1;
      cycle("R6");
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 4; k++) m_reg[k] = '0;
      m_ar = '0;
      m_dr = '0;
      @(negedge clk);
      rst = 1'b1;
      cycle("R11");

      // R2: each destination code loads its own register only
      for (int k = 0; k < 4; k++) put_reg(k, DW'(16'h1111 * (k + 1)), "R2");
      // R1: literal bus drive observed before the edge
      lit_en = 1'b1; lit_data = 16'hA5C3;
      cycle("R1");

      // R4: condition low blocks every bus load
      lit_en = 1'b1; lit_data = 16'hDEAD; dst_sel = 2'd1; ld_en = 1'b1;
      ar_ld = 1'b1; dr_ld = 1'b1; cond = 1'b0;
      cycle("R4");

      // R5: register to register moves, including onto itself
      src_sel = 2'd0; dst_sel = 2'd3; ld_en = 1'b1; cond = 1'b1; cycle("R5");
      src_sel = 2'd2; dst_sel = 2'd2; ld_en = 1'b1; cond = 1'b1; cycle("R5");
      src_sel = 2'd1; dst_sel = 2'd0; ld_en = 1'b1; cond = 1'b1; cycle("R5");

      // R3: strobes high through the low phase; compared just before the edge
      src_sel = 2'd3; ar_ld = 1'b1; dr_ld = 1'b1; cond = 1'b1; cycle("R3");

      // R7 and R12: write through an address with upper bits set, read via alias
      put_ar(16'h1205);
      put_dr(16'hBEEF);
      cs = 1'b1; wr_en = 1'b1; cycle("R7");
      put_dr(16'h0000);
      put_ar(16'h0005);
      cs = 1'b1; rd_en = 1'b1; cycle("R12");

      // R9: no chip select means no write and no read
      put_ar(16'h0010);
      put_dr(16'hAAAA);
      cs = 1'b1; wr_en = 1'b1; cycle("R7");
      put_dr(16'h5555);
      cs = 1'b0; wr_en = 1'b1; cycle("R9");
      put_dr(16'h1234);
      cs = 1'b0; rd_en = 1'b1; cycle("R9");
      cs = 1'b1; rd_en = 1'b1; cycle("R9");

      // R8: read has priority over a bus load of DR
      put_dr(16'h0F0F);
      lit_en = 1'b1; lit_data = 16'h7777; dr_ld = 1'b1; cond = 1'b1;
      cs = 1'b1; rd_en = 1'b1; cycle("R8");

      // R10: read and write together: word written, DR not loaded from memory
      put_dr(16'h3333);
      cs = 1'b1; rd_en = 1'b1; wr_en = 1'b1; cycle("R10");
      put_dr(16'h0000);
      cs = 1'b1; rd_en = 1'b1; cycle("R10");

      // R7 and R8 over a range of addresses
      for (int a = 32; a < 48; a++) begin
         put_ar(DW'(a));
         put_dr(DW'(a * 16'h0101 + 16'h4000));
         cs = 1'b1; wr_en = 1'b1; cycle("R7");
      end
      for (int a = 32; a < 48; a++) begin
         put_ar(DW'(a));
         cs = 1'b1; rd_en = 1'b1; cycle("R8");
      end

      // R11: reset overrides loads
      put_reg(2, 16'h9999, "R2");
      rst = 1'b1; lit_en = 1'b1; lit_data = 16'hFFFF; dst_sel = 2'd2;
      ld_en = 1'b1; ar_ld = 1'b1; dr_ld = 1'b1; cond = 1'b1;
      cycle("R11");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule